// File: doc/BRIEF.md
# Masked-Write Software Trigger Register

This block is one 16-bit register on a simple synchronous register bus. It holds eight software trigger flags. Software sets or clears any group of these flags in a single write, with no read-modify-write. Each write carries two bytes. The upper byte is a per-flag write mask and the lower byte holds the new flag values. A flag changes only when its mask bit is 1 in that same access. The mask is used for that write and then discarded, so the upper byte always reads back as zero.

Each flag drives one request output. A request is asserted only while the global interrupt-enable input is high. Only bus writes change the flags. A read, the enable input and the request outputs never modify them. No mode or state restricts access, so the register accepts a read or a write on any cycle after reset.

There is no sequencing. The behaviour is one register stage, with combinational decode in front of it and combinational gating after it.

Top module: `swtrig_reg`

## Requirements
- R1: After reset, all sixteen bits of `rd_data` are zero and every `trig_req` bit is zero.
- R2: On a full write (`bus_sel`=1, `bus_wr`=1, `bus_be`=2'b11), each flag i whose mask bit `wr_data[8+i]` is 1 and whose value bit `wr_data[i]` is 1 reads back as 1 from the next cycle.
- R3: On a full write, each flag i whose mask bit `wr_data[8+i]` is 1 and whose value bit `wr_data[i]` is 0 reads back as 0 from the next cycle.
- R4: On a full write, each flag whose mask bit `wr_data[8+i]` is 0 keeps its previous value.
- R5: `rd_data[15:8]` is always zero, whatever mask was last written. `rd_data[7:0]` shows the current flags (bit i is flag i).
- R6: `trig_req[i]` equals flag i AND `irq_en`, in the same cycle, with no added latency.
- R7: A write with `bus_be`=2'b10 (upper byte only) changes no flag.
- R8: A write with `bus_be`=2'b01 (lower byte only) changes no flag, because the mask counts as all zeros.
- R9: A cycle without both `bus_sel` and `bus_wr` high changes no flag. This includes reads (`bus_sel`=1, `bus_wr`=0) and any value of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register select |
| bus_wr | input | 1 | Write strobe; a write needs both `bus_sel` and `bus_wr` high |
| bus_be | input | 2 | Byte enables; bit 1 covers the mask byte, bit 0 covers the value byte |
| wr_data | input | 16 | Write data: mask in bits 15..8, new flag values in bits 7..0 |
| rd_data | output | 16 | Read data: zeros in bits 15..8, flags in bits 7..0 |
| irq_en | input | 1 | Global enable that qualifies every request output |
| trig_req | output | 8 | Per-flag request, flag AND `irq_en` |

## Verification
Directed writes come first:
- A full mask that sets every flag.
- A partial mask that clears only some set flags while the others hold. This separates masked bits from unmasked ones.
- Upper-only and lower-only byte-enable writes carrying data that would change flags. These show that neither half-write leaks through.
- Unselected cycles, strobe-less cycles and reads that carry the same hostile data.

Random cycles from a seeded generator then mix every byte-enable pattern, select and strobe combination, arbitrary masks and toggling `irq_en`. They are compared with a bench model after each edge. `trig_req` is also checked right after `irq_en` changes and before the next edge, which separates a combinational gate from a registered one.

// File: rtl/swtrig_pkg.sv
package swtrig_pkg;

    // Number of software trigger flags held by the register
    localparam int unsigned SWT_COUNT = 8;

    // Bus width: one mask byte above one value byte
    localparam int unsigned SWT_BUS_W = 2 * SWT_COUNT;

    // Byte-enable encodings seen on the bus
    typedef enum logic [1:0] {
        BE_NONE  = 2'b00,
        BE_LOW   = 2'b01,
        BE_HIGH  = 2'b10,
        BE_FULL  = 2'b11
    } swt_be_e;

endpackage

// File: rtl/swtrig_wr_decode.sv
module swtrig_wr_decode #(
    parameter int unsigned NTRIG = swtrig_pkg::SWT_COUNT,
    localparam int unsigned BUS_W = 2 * NTRIG
) (
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_be,
    input  logic [BUS_W-1:0] wr_data,
    output logic [NTRIG-1:0] upd_mask,
    output logic [NTRIG-1:0] upd_val
);
    import swtrig_pkg::*;

    logic             access;
    logic [NTRIG-1:0] mask_byte;

    assign access = bus_sel & bus_wr;

    // A mask byte that is not enabled counts as all zeros
    always_comb begin
        unique case (swt_be_e'(bus_be))
            BE_FULL:  mask_byte = wr_data[BUS_W-1:NTRIG];
            BE_HIGH,
            BE_LOW,
            BE_NONE:  mask_byte = '0;
            default:  mask_byte = '0;
        endcase
    end

    assign upd_mask = access ? mask_byte : '0;
    assign upd_val  = wr_data[NTRIG-1:0];

endmodule

// File: rtl/swtrig_flag_bank.sv
module swtrig_flag_bank #(
    parameter int unsigned NTRIG = swtrig_pkg::SWT_COUNT
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NTRIG-1:0] upd_mask,
    input  logic [NTRIG-1:0] upd_val,
    output logic [NTRIG-1:0] flag_q
);

    for (genvar i = 0; i < NTRIG; i++) begin : g_flag
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                flag_q[i] <= 1'b0;
            end else if (upd_mask[i]) begin
                flag_q[i] <= upd_val[i];
            end
        end
    end

    // R4
    unmasked_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_mask == '0) |=> $stable(flag_q));

    // R2
    masked_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_mask != '0) |=> ((flag_q & $past(upd_mask)) == ($past(upd_val) & $past(upd_mask))));

endmodule

// File: rtl/swtrig_req_gate.sv
module swtrig_req_gate #(
    parameter int unsigned NTRIG = swtrig_pkg::SWT_COUNT
) (
    input  logic [NTRIG-1:0] flag_q,
    input  logic             irq_en,
    output logic [NTRIG-1:0] trig_req
);

    for (genvar i = 0; i < NTRIG; i++) begin : g_req
        assign trig_req[i] = flag_q[i] & irq_en;
    end

endmodule

// File: rtl/swtrig_reg.sv
module swtrig_reg #(
    parameter int unsigned NTRIG = swtrig_pkg::SWT_COUNT,
    localparam int unsigned BUS_W = 2 * NTRIG
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [1:0]       bus_be,
    input  logic [BUS_W-1:0] wr_data,
    output logic [BUS_W-1:0] rd_data,
    input  logic             irq_en,
    output logic [NTRIG-1:0] trig_req
);

    logic [NTRIG-1:0] upd_mask;
    logic [NTRIG-1:0] upd_val;
    logic [NTRIG-1:0] flag_q;

    swtrig_wr_decode #(.NTRIG(NTRIG)) u_decode (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_be   (bus_be),
        .wr_data  (wr_data),
        .upd_mask (upd_mask),
        .upd_val  (upd_val)
    );

    swtrig_flag_bank #(.NTRIG(NTRIG)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .upd_mask (upd_mask),
        .upd_val  (upd_val),
        .flag_q   (flag_q)
    );

    swtrig_req_gate #(.NTRIG(NTRIG)) u_gate (
        .flag_q   (flag_q),
        .irq_en   (irq_en),
        .trig_req (trig_req)
    );

    // Mask byte is never stored
    assign rd_data = {{NTRIG{1'b0}}, flag_q};

    // R3
    full_write_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be == 2'b11)
        |=> ((~rd_data[NTRIG-1:0] & $past(wr_data[BUS_W-1:NTRIG]))
             == (~$past(wr_data[NTRIG-1:0]) & $past(wr_data[BUS_W-1:NTRIG]))));

    // R6
    req_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_req == (rd_data[NTRIG-1:0] & {NTRIG{irq_en}}));

    // R7
    upper_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be == 2'b10) |=> $stable(rd_data));

    // R8
    lower_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_be == 2'b01) |=> $stable(rd_data));

    // R9
    no_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wr) |=> $stable(rd_data));

endmodule

// File: tb/swtrig_reg_bench.sv
module swtrig_reg_bench;

    localparam int NT = 8;
    localparam int BW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [1:0]    bus_be = 2'b00;
    logic [BW-1:0] wr_data = '0;
    logic [BW-1:0] rd_data;
    logic          irq_en = 1'b0;
    logic [NT-1:0] trig_req;

    int checks = 0;
    int errors = 0;
    logic [NT-1:0] model = '0;

    always #5 clk = ~clk;

    swtrig_reg u_swtrig_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_be   (bus_be),
        .wr_data  (wr_data),
        .rd_data  (rd_data),
        .irq_en   (irq_en),
        .trig_req (trig_req)
    );

    // Next flag state from the requirements (R2, R3, R4, R7, R8, R9)
    function automatic logic [NT-1:0] next_flags(input logic [NT-1:0] cur, input logic s,
                                                 input logic w, input logic [1:0] be,
                                                 input logic [BW-1:0] d);
        logic [NT-1:0] m;
        if (s && w && be == 2'b11) begin
            m = d[BW-1:NT];
            return (cur & ~m) | (d[NT-1:0] & m);
        end
        return cur;
    endfunction

    function automatic logic [NT-1:0] exp_req(input logic [NT-1:0] f, input logic en);
        return en ? f : '0;
    endfunction

    task automatic check(input string tag, input logic [BW-1:0] act, input logic [BW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Drive one cycle at the falling edge, check req before the edge, readback after
    task automatic cycle(input string tag, input logic s, input logic w, input logic [1:0] be,
                         input logic [BW-1:0] d, input logic en);
        bus_sel = s; bus_wr = w; bus_be = be; wr_data = d; irq_en = en;
        #1;
        check({tag, " R6 comb"}, {8'h00, trig_req}, {8'h00, exp_req(model, en)});
        model = next_flags(model, s, w, be, d);
        @(negedge clk);
        check({tag, " R5 rd"}, rd_data, {8'h00, model});
        check({tag, " R6 req"}, {8'h00, trig_req}, {8'h00, exp_req(model, en)});
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 rd", rd_data, 16'h0000);
        check("R1 req", {8'h00, trig_req}, 16'h0000);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after release", rd_data, 16'h0000);

        // R2 set all with full mask
        cycle("R2 set all", 1, 1, 2'b11, 16'hFFFF, 1);
        check("R2 all set", rd_data, 16'h00FF);
        // R3 clear low nibble, R4 high nibble untouched
        cycle("R3 clear", 1, 1, 2'b11, 16'h0F00, 1);
        check("R3 cleared", rd_data, 16'h00F0);
        cycle("R4 hold", 1, 1, 2'b11, 16'h0300, 1);
        check("R4 held", rd_data, 16'h00F0);
        // R7 upper-only write
        cycle("R7 upper", 1, 1, 2'b10, 16'hFF0F, 1);
        check("R7 unchanged", rd_data, 16'h00F0);
        // R8 lower-only write
        cycle("R8 lower", 1, 1, 2'b01, 16'hFF0F, 1);
        check("R8 unchanged", rd_data, 16'h00F0);
        // R9 unselected, no strobe, read
        cycle("R9 nosel", 0, 1, 2'b11, 16'hFF0F, 1);
        cycle("R9 nowr", 1, 0, 2'b11, 16'hFF0F, 0);
        cycle("R9 read", 1, 0, 2'b00, 16'h0000, 1);
        check("R9 unchanged", rd_data, 16'h00F0);
        // R6 disable then enable
        cycle("R6 off", 0, 0, 2'b00, 16'h0000, 0);
        check("R6 gated", {8'h00, trig_req}, 16'h0000);
        cycle("R6 on", 0, 0, 2'b00, 16'h0000, 1);
        check("R6 open", {8'h00, trig_req}, 16'h00F0);

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            logic [31:0] r;
            r = $urandom;
            cycle("RND R2 R3 R4 R7 R8 R9", r[0] | r[1], r[2] | r[3], r[5:4],
                  r[21:6], r[22]);
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule